// File: doc/BRIEF.md
# Post-Modify Circular Address Generator

This block supplies memory addresses for indirect operand fetches. It holds four address pointers and four modify registers. Each pointer also has its own length register and its own buffer base register. When an access is requested, the block issues the selected pointer's present value as the address. In the same clock edge it advances that pointer by a separately selected modify value.

Modify values are signed two's-complement numbers, so a pointer can step forward or backward. When the pointer's length is zero, the update is a plain 14-bit addition. When the length is nonzero, the pointer stays inside a circular buffer that starts at its base and spans its length. A single write port loads any pointer, modify, length or base register. A write to a pointer in the same cycle as an access to that pointer overrides the post-modify result.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset all pointers, modify, length and base registers hold zero and `addr_valid` is low.
- R2: An access sampled on a rising edge sets `addr_valid` high for exactly the following cycle. In that cycle `addr_out` equals the pointer value from before the access.
- R3: After an access, the selected pointer holds its old value plus the modify register chosen by `acc_mod_sel`, and any of the four modify registers can be chosen.
- R4: With a length of zero the update is plain addition modulo 2^14, so 16383 plus 1 gives 0.
- R5: With a nonzero length L and base B, a sum at or above B+L has L subtracted from it.
- R6: With a nonzero length L and base B, a sum below B has L added to it.
- R7: Modify registers are signed 14-bit values, so a negative modify moves the pointer backward.
- R8: A pointer write and an access to the same pointer in one cycle issue the old value and leave the written value in the pointer.
- R9: An access changes only the selected pointer. All other pointers keep their values.
- R10: The `wr_kind` encoding is 0 for pointer, 1 for modify, 2 for length and 3 for base, and `wr_idx` selects the register. A write with no access leaves `addr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access request |
| acc_ptr_sel | input | 2 | Pointer used by the access |
| acc_mod_sel | input | 2 | Modify register used by the access |
| wr_en | input | 1 | Register write enable |
| wr_kind | input | 2 | Register class to write (0 pointer, 1 modify, 2 length, 3 base) |
| wr_idx | input | 2 | Register index within the class |
| wr_data | input | 14 | Write data |
| addr_out | output | 14 | Issued address |
| addr_valid | output | 1 | Address strobe, high one cycle per access |

## Verification
The bench first steps a pointer from 16383 by +1. A design that held the carry or saturated would issue 16384-wrapped garbage or stick at the top instead of reaching 0. It then drives a circular buffer across its upper and lower edges with forward and backward modifies. A design with an off-by-one bound would issue an address equal to B+L or one below B. Finally it writes a pointer in the same cycle as an access to it. A design that gives the wrong priority would expose the post-modified value on the next access instead of the written one. Interleaved accesses to several pointers catch any update that lands on the wrong pointer.

// File: rtl/cag_pkg.sv
package cag_pkg;
    typedef enum logic [1:0] {
        WK_PTR  = 2'd0,
        WK_MOD  = 2'd1,
        WK_LEN  = 2'd2,
        WK_BASE = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/cag_wrap.sv
module cag_wrap #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] mod,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] nxt
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum_d, lo_d, hi_d, len_s, adj_d;
    logic [EW-AW-1:0] unused_hi;

    always_comb begin
        sum_d = $signed({2'b00, ptr}) + $signed({{2{mod[AW-1]}}, mod});
        len_s = $signed({2'b00, len});
        lo_d  = $signed({2'b00, base});
        hi_d  = lo_d + len_s;
        if (len == '0)
            adj_d = sum_d;
        else if (sum_d >= hi_d)
            adj_d = sum_d - len_s;
        else if (sum_d < lo_d)
            adj_d = sum_d + len_s;
        else
            adj_d = sum_d;
        nxt       = adj_d[AW-1:0];
        unused_hi = adj_d[EW-1:AW];
    end
endmodule

// File: rtl/cag_bank.sv
module cag_bank
    import cag_pkg::*;
#(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    parameter int NMOD = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_req,
    input  logic [$clog2(NPTR)-1:0] ptr_sel,
    input  logic [$clog2(NMOD)-1:0] mod_sel,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [$clog2(NPTR)-1:0] wr_idx,
    input  logic [AW-1:0]           wr_data,
    input  logic [AW-1:0]           nxt_ptr,
    output logic [AW-1:0]           sel_ptr,
    output logic [AW-1:0]           sel_mod,
    output logic [AW-1:0]           sel_len,
    output logic [AW-1:0]           sel_base,
    output logic [AW-1:0]           addr_out,
    output logic                    addr_valid
);
    localparam int SW = $clog2(NPTR);
    localparam int MW = $clog2(NMOD);

    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] ptr;
        logic [NMOD-1:0][AW-1:0] mod;
        logic [NPTR-1:0][AW-1:0] len;
        logic [NPTR-1:0][AW-1:0] base;
        logic [AW-1:0]           addr;
        logic                    vld;
    } bank_t;

    bank_t    st_d, st_q;
    wr_kind_e kind;
    logic     unused_idx;

    assign kind = wr_kind_e'(wr_kind);

    always_comb begin
        st_d     = st_q;
        st_d.vld = acc_req;
        if (acc_req) begin
            st_d.addr         = st_q.ptr[ptr_sel];
            st_d.ptr[ptr_sel] = nxt_ptr;
        end
        if (wr_en) begin
            case (kind)
                WK_PTR:  st_d.ptr[wr_idx]  = wr_data;
                WK_MOD:  st_d.mod[MW'(wr_idx)] = wr_data;
                WK_LEN:  st_d.len[wr_idx]  = wr_data;
                default: st_d.base[wr_idx] = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_ptr    = st_q.ptr[ptr_sel];
    assign sel_mod    = st_q.mod[mod_sel];
    assign sel_len    = st_q.len[ptr_sel];
    assign sel_base   = st_q.base[ptr_sel];
    assign addr_out   = st_q.addr;
    assign addr_valid = st_q.vld;
    assign unused_idx = 1'b0;

    // Written pointer value wins over post-modify (R8)
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == WK_PTR) |=> st_q.ptr[$past(wr_idx)] == $past(wr_data));

    for (genvar i = 0; i < NPTR; i++) begin : g_hold
        assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!(acc_req && ptr_sel == SW'(i)) && !(wr_en && kind == WK_PTR && wr_idx == SW'(i)))
            |=> $stable(st_q.ptr[i]));
    end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
    parameter int AW   = 14,
    parameter int NPTR = 4,
    parameter int NMOD = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_req,
    input  logic [$clog2(NPTR)-1:0] acc_ptr_sel,
    input  logic [$clog2(NMOD)-1:0] acc_mod_sel,
    input  logic                    wr_en,
    input  logic [1:0]              wr_kind,
    input  logic [$clog2(NPTR)-1:0] wr_idx,
    input  logic [AW-1:0]           wr_data,
    output logic [AW-1:0]           addr_out,
    output logic                    addr_valid
);
    logic [AW-1:0] sel_ptr, sel_mod, sel_len, sel_base, nxt_ptr;

    cag_bank #(.AW(AW), .NPTR(NPTR), .NMOD(NMOD)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .ptr_sel    (acc_ptr_sel),
        .mod_sel    (acc_mod_sel),
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .nxt_ptr    (nxt_ptr),
        .sel_ptr    (sel_ptr),
        .sel_mod    (sel_mod),
        .sel_len    (sel_len),
        .sel_base   (sel_base),
        .addr_out   (addr_out),
        .addr_valid (addr_valid)
    );

    cag_wrap #(.AW(AW)) u_wrap (
        .ptr  (sel_ptr),
        .mod  (sel_mod),
        .len  (sel_len),
        .base (sel_base),
        .nxt  (nxt_ptr)
    );

    logic [AW:0]   win_end;
    logic [AW-1:0] mod_mag;
    logic          cur_in, nxt_in, mag_ok;

    always_comb begin
        win_end = {1'b0, sel_base} + {1'b0, sel_len};
        mod_mag = sel_mod[AW-1] ? (~sel_mod + 1'b1) : sel_mod;
        cur_in  = (sel_ptr >= sel_base) && ({1'b0, sel_ptr} < win_end);
        nxt_in  = (nxt_ptr >= sel_base) && ({1'b0, nxt_ptr} < win_end);
        mag_ok  = (mod_mag <= sel_len) && !win_end[AW];
    end

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> addr_valid);
    assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !addr_valid);
    assert_stay_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && sel_len != '0 && cur_in && mag_ok) |-> nxt_in);
endmodule

// File: tb/sim_circ_addr_gen.sv
`timescale 1ns/1ps
module sim_circ_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_ptr_sel = '0, acc_mod_sel = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0, wr_idx = '0;
    logic [13:0] wr_data = '0;
    logic [13:0] addr_out;
    logic        addr_valid;

    int n_cmp = 0, n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    int m_ptr[4], m_mod[4], m_len[4], m_base[4];

    always #10 clk = ~clk;

    circ_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_ptr_sel(acc_ptr_sel),
        .acc_mod_sel(acc_mod_sel), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
        .wr_data(wr_data), .addr_out(addr_out), .addr_valid(addr_valid)
    );

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_ptr(int p, int m);
        int s = m_ptr[p] + ((m_mod[m] >= 8192) ? m_mod[m] - 16384 : m_mod[m]);
        if (m_len[p] != 0) begin
            if (s >= m_base[p] + m_len[p]) s = s - m_len[p];
            else if (s < m_base[p])        s = s + m_len[p];
        end
        return s & 16383;
    endfunction

    // driver: one cycle of stimulus, expected issue pushed to scoreboard
    task automatic cycle(bit acc, int p, int m, bit wr, int k, int idx, int d, string tag);
        acc_req = acc; acc_ptr_sel = 2'(p); acc_mod_sel = 2'(m);
        wr_en = wr; wr_kind = 2'(k); wr_idx = 2'(idx); wr_data = 14'(d);
        if (acc) begin
            exp_q.push_back(m_ptr[p]);
            tag_q.push_back(tag);
            m_ptr[p] = next_ptr(p, m);
        end
        if (wr) case (k)
            0: m_ptr[idx]  = d & 16383;
            1: m_mod[idx]  = d & 16383;
            2: m_len[idx]  = d & 16383;
            default: m_base[idx] = d & 16383;
        endcase
        @(negedge clk);
        acc_req = 1'b0; wr_en = 1'b0;
    endtask

    task automatic acc(int p, int m, string tag);
        cycle(1, p, m, 0, 0, 0, 0, tag);
    endtask
    task automatic wr(int k, int idx, int d);
        cycle(0, 0, 0, 1, k, idx, d, "");
    endtask

    // monitor: pops scoreboard whenever a strobe is seen
    always @(negedge clk) begin
        if (rst_n && addr_valid) begin
            if (exp_q.size() == 0) check("R10 unexpected strobe", 1, 0);
            else check(tag_q.pop_front(), int'(addr_out), exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ptr[i] = 0; m_mod[i] = 0; m_len[i] = 0; m_base[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", int'(addr_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid low after reset", int'(addr_valid), 0);
        for (int i = 0; i < 4; i++) acc(i, i, "R1 pointer zero");
        acc(0, 0, "R1 pointer still zero");
        // R10 register setup through write port
        wr(0, 0, 100); wr(0, 1, 200); wr(0, 2, 300); wr(0, 3, 400);
        wr(1, 0, 1); wr(1, 1, 4); wr(1, 2, 16381); wr(1, 3, 5);
        @(negedge clk);
        check("R10 no strobe on writes", int'(addr_valid), 0);
        // R3: each modify register, back to back (R2)
        acc(0, 0, "R3 mod0"); acc(0, 0, "R3 mod0 again"); acc(0, 1, "R3 mod1");
        acc(0, 3, "R3 mod3"); acc(0, 2, "R3 mod2"); acc(0, 0, "R2 post value");
        // R7 backward steps
        acc(2, 2, "R7 back"); acc(2, 2, "R7 back"); acc(2, 2, "R7 back");
        // R9 other pointers untouched
        acc(1, 0, "R9 p1 unchanged"); acc(3, 0, "R9 p3 unchanged");
        // R4 plain wrap
        wr(0, 1, 16383);
        acc(1, 0, "R4 top"); acc(1, 0, "R4 wrapped to zero"); acc(1, 0, "R4 after wrap");
        // R5 upper edge of circular buffer
        wr(3, 3, 1000); wr(2, 3, 10); wr(0, 3, 1008);
        acc(3, 1, "R5 up"); acc(3, 1, "R5 up"); acc(3, 1, "R5 up"); acc(3, 1, "R5 up");
        acc(3, 1, "R5 up");
        // R6 lower edge
        acc(3, 2, "R6 down"); acc(3, 2, "R6 down"); acc(3, 2, "R6 down");
        acc(3, 2, "R6 down"); acc(3, 2, "R6 down"); acc(3, 2, "R6 down");
        // R8 write collides with access to same pointer
        cycle(1, 0, 1, 1, 0, 0, 5000, "R8 old value issued");
        acc(0, 0, "R8 written value kept"); acc(0, 0, "R8 continues");
        // R8 write to another pointer during access
        cycle(1, 2, 0, 1, 0, 1, 777, "R8 other access");
        acc(1, 0, "R8 other write"); acc(2, 0, "R9 accessed pointer");
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule